// File: doc/BRIEF.md
# Bus Arbitration Waiter Queue

This block sits between the transaction sources of one cache and a shared bus arbiter. The arbiter sees at most one request from this cache at a time. Every other pending transaction waits in a local double-ended queue. A counter covers the presented request plus all queued waiters. When the arbiter grants the presented request, the oldest waiter is presented next. The block also reports how many bus cycles each presented transaction will occupy, based on its kind and byte size.

A coherence data response must never wait behind requests that may be stalled. When one arrives while another request is presented, it takes that request's place at once. The displaced request goes back to the head of the queue, so it is the next one presented after the response is granted. Only one data response may be outstanding per cache. A second one that arrives while the first is still ungranted is dropped, and an error pulse is raised.

Top module: `bus_arb_waitq`

## Requirements
- R1: After reset, arbValid is 0, waitCount is 0, reqReady is 1 and errDupResp is 0.
- R2: A request accepted while waitCount is 0 is presented on the arbiter outputs in the next cycle, and waitCount becomes 1.
- R3: A non-response request accepted while another request is presented joins the tail of the queue, and waitCount increments. Queued requests are presented in arrival order.
- R4: A grant (arbValid and arbGrant both high) removes the presented request and decrements waitCount. The queue head is presented in the next cycle. If nothing is waiting, arbValid drops.
- R5: A data response (kind 4) accepted while a request is presented, with no grant in that cycle, is presented in the next cycle. The displaced request goes to the queue head and is presented right after the response is granted. waitCount increments.
- R6: A data response accepted in the same cycle as a grant is presented in the next cycle, and waitCount is unchanged.
- R7: While arbValid is high, the presented kind and tag stay unchanged until a grant occurs or a data response displaces them.
- R8: A data response that arrives while an earlier response is presented and ungranted is dropped. errDupResp is high for exactly the next cycle, and waitCount and the presented request are unchanged.
- R9: arbBeats gives the bus cycles of the presented request. Kind 0 (coherent request) and kind 1 (uncached read) take 1. Kind 2 (uncached write) and kind 3 (uncached swap) take 1 + ceil(size / BUS_BYTES). Kind 4 (data response) takes LINE_BYTES / BUS_BYTES.
- R10: reqReady is low while the queue holds DEPTH waiters, that is, while waitCount equals DEPTH + 1. A request offered while reqReady is low is ignored.
- R11: A non-response request accepted in the same cycle as a grant joins the queue tail. The queue head is presented next, and waitCount is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | New transaction offered |
| reqKind | input | 3 | Transaction kind, encoded 0 to 4 as in R9 |
| reqSize | input | SIZE_W | Transfer size in bytes |
| reqTag | input | TAG_W | Transaction identifier |
| reqReady | output | 1 | Queue can accept a transaction |
| arbValid | output | 1 | Request presented to the arbiter |
| arbKind | output | 3 | Kind of the presented request |
| arbTag | output | TAG_W | Tag of the presented request |
| arbBeats | output | BEAT_W | Bus cycles the presented request occupies |
| arbGrant | input | 1 | Arbiter grants the presented request |
| waitCount | output | CNT_W | Presented request plus queued waiters |
| errDupResp | output | 1 | One-cycle pulse when a second data response is dropped |

## Verification
The main function is tried with four kinds of stimulus. A plain burst followed by grants distinguishes head order from tail order. A response that arrives behind two queued requests shows that the displaced request returns to the head and not the tail. Stimulus in the same cycle as a grant separates the simultaneous pop-and-push path from the push-only path, for both normal requests and responses. Filling the queue to DEPTH waiters and offering one more transaction shows the full boundary and confirms that the refused transaction never appears during the drain.

// File: rtl/waitq_pkg.sv
package waitq_pkg;
  parameter int TAG_W  = 8;
  parameter int SIZE_W = 8;

  typedef enum logic [2:0] {
    K_COH  = 3'd0,
    K_UCRD = 3'd1,
    K_UCWR = 3'd2,
    K_UCSW = 3'd3,
    K_RESP = 3'd4
  } kind_e;

  typedef struct packed {
    kind_e             kind;
    logic [SIZE_W-1:0] size;
    logic [TAG_W-1:0]  tag;
  } entry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadNew;   // presented <= incoming
    logic loadHead;  // presented <= queue head, pop
    logic pushTail;  // incoming -> queue tail
    logic pushHead;  // presented -> queue head
    logic clearPres; // nothing left to present
  } strobe_t;
endpackage

// File: rtl/waitq_ctrl.sv
module waitq_ctrl
  import waitq_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  kind_e            reqKind,
  input  logic             arbGrant,
  input  logic             presValid,
  input  kind_e            presKind,
  input  logic [CNT_W-1:0] fifoCnt,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  output strobe_t          stb,
  output logic             reqReady,
  output logic [CNT_W-1:0] waitCount,
  output logic             errDupResp
);
  logic respPending;
  logic grantFire, isResp, dup, take;

  assign reqReady  = !fifoFull;
  assign grantFire = presValid && arbGrant;
  assign isResp    = (reqKind == K_RESP);
  assign dup       = reqValid && reqReady && isResp && respPending && !grantFire;
  assign take      = reqValid && reqReady && !dup;

  always_comb begin
    stb = '0;
    if (take) begin
      if (!presValid) begin
        stb.loadNew = 1'b1;
      end else if (grantFire) begin
        if (isResp || fifoEmpty) stb.loadNew = 1'b1;
        else begin
          stb.loadHead = 1'b1;
          stb.pushTail = 1'b1;
        end
      end else if (isResp) begin
        stb.pushHead = 1'b1;
        stb.loadNew  = 1'b1;
      end else begin
        stb.pushTail = 1'b1;
      end
    end else if (grantFire) begin
      if (fifoEmpty) stb.clearPres = 1'b1;
      else           stb.loadHead  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      waitCount   <= '0;
      respPending <= 1'b0;
      errDupResp  <= 1'b0;
    end else begin
      waitCount   <= waitCount + CNT_W'(take) - CNT_W'(grantFire);
      respPending <= (respPending && !grantFire) || (take && isResp);
      errDupResp  <= dup;
    end
  end

  // R4: the counter always equals the presented entry plus queue occupancy
  a_r4_count_tracks: assert property (@(posedge clk) disable iff (!rstN)
    waitCount == fifoCnt + CNT_W'(presValid));

  // R8: the outstanding-response flag agrees with what the datapath presents
  a_r8_resp_flag: assert property (@(posedge clk) disable iff (!rstN)
    respPending == (presValid && presKind == K_RESP));
endmodule

// File: rtl/waitq_datapath.sv
module waitq_datapath
  import waitq_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int BUS_BYTES  = 8,
  parameter int LINE_BYTES = 64,
  parameter int CNT_W      = 4,
  parameter int BEAT_W     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  entry_t            inEntry,
  output logic              presValid,
  output entry_t            presEntry,
  output logic [BEAT_W-1:0] presBeats,
  output logic [CNT_W-1:0]  fifoCnt,
  output logic              fifoFull,
  output logic              fifoEmpty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  entry_t           mem [DEPTH];
  logic [PTR_W-1:0] headPtr, tailPtr, headPrev;

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PTR_W-1:0] ptrDec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH-1) : p - 1'b1;
  endfunction

  assign headPrev  = ptrDec(headPtr);
  assign fifoFull  = (fifoCnt == CNT_W'(DEPTH));
  assign fifoEmpty = (fifoCnt == '0);

  always_ff @(posedge clk) begin
    if (stb.pushTail) mem[tailPtr]  <= inEntry;
    if (stb.pushHead) mem[headPrev] <= presEntry;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      fifoCnt   <= '0;
      presValid <= 1'b0;
      presEntry <= '0;
    end else begin
      if (stb.pushTail) tailPtr <= ptrInc(tailPtr);
      if (stb.pushHead) headPtr <= headPrev;
      else if (stb.loadHead) headPtr <= ptrInc(headPtr);
      fifoCnt <= fifoCnt + CNT_W'(stb.pushTail) + CNT_W'(stb.pushHead)
                         - CNT_W'(stb.loadHead);
      if (stb.loadNew) begin
        presValid <= 1'b1;
        presEntry <= inEntry;
      end else if (stb.loadHead) begin
        presValid <= 1'b1;
        presEntry <= mem[headPtr];
      end else if (stb.clearPres) begin
        presValid <= 1'b0;
      end
    end
  end

  // bus occupancy of the presented entry
  always_comb begin
    int unsigned b;
    case (presEntry.kind)
      K_UCWR, K_UCSW: b = 1 + (int'(presEntry.size) + BUS_BYTES - 1) / BUS_BYTES;
      K_RESP:         b = LINE_BYTES / BUS_BYTES;
      default:        b = 1;
    endcase
    presBeats = BEAT_W'(b);
  end

  // R10: no push into a full queue unless a pop frees a slot in the same cycle
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !stb.pushHead && !(stb.pushTail && !stb.loadHead));

  // R5: head and tail inserts never coincide; no pop from an empty queue
  a_r5_single_insert: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.pushHead && stb.pushTail) && !(stb.loadHead && fifoEmpty));
endmodule

// File: rtl/bus_arb_waitq.sv
module bus_arb_waitq
  import waitq_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int BUS_BYTES  = 8,
  parameter int LINE_BYTES = 64,
  localparam int CNT_W     = $clog2(DEPTH + 2),
  localparam int MAX_WR    = 1 + ((1 << SIZE_W) + BUS_BYTES - 2) / BUS_BYTES,
  localparam int MAX_LN    = LINE_BYTES / BUS_BYTES,
  localparam int BEAT_W    = $clog2(((MAX_WR > MAX_LN) ? MAX_WR : MAX_LN) + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [TAG_W-1:0]  reqTag,
  output logic              reqReady,
  output logic              arbValid,
  output logic [2:0]        arbKind,
  output logic [TAG_W-1:0]  arbTag,
  output logic [BEAT_W-1:0] arbBeats,
  input  logic              arbGrant,
  output logic [CNT_W-1:0]  waitCount,
  output logic              errDupResp
);
  strobe_t          stb;
  entry_t           inEntry, presEntry;
  logic [CNT_W-1:0] fifoCnt;
  logic             fifoFull, fifoEmpty;

  assign inEntry = '{kind: kind_e'(reqKind), size: reqSize, tag: reqTag};
  assign arbKind = presEntry.kind;
  assign arbTag  = presEntry.tag;

  waitq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(kind_e'(reqKind)),
    .arbGrant(arbGrant), .presValid(arbValid), .presKind(presEntry.kind),
    .fifoCnt(fifoCnt), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .stb(stb), .reqReady(reqReady), .waitCount(waitCount), .errDupResp(errDupResp)
  );

  waitq_datapath #(
    .DEPTH(DEPTH), .BUS_BYTES(BUS_BYTES), .LINE_BYTES(LINE_BYTES),
    .CNT_W(CNT_W), .BEAT_W(BEAT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inEntry(inEntry),
    .presValid(arbValid), .presEntry(presEntry), .presBeats(arbBeats),
    .fifoCnt(fifoCnt), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );

  // R7: presented request holds until granted or displaced by a response
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    arbValid && !arbGrant && !(reqValid && reqReady && reqKind == 3'd4)
    |=> arbValid && $stable(arbTag) && $stable(arbKind));

  // R8: an error pulse follows only an offered data response
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rstN)
    errDupResp |-> $past(reqValid && reqKind == 3'd4));
endmodule

// File: tb/bus_arb_waitq_test.sv
module bus_arb_waitq_test;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqKind = 3'd0;
  logic [7:0] reqSize = 8'd0;
  logic [7:0] reqTag = 8'd0;
  logic       arbGrant = 1'b0;
  logic       reqReady, arbValid, errDupResp;
  logic [2:0] arbKind;
  logic [7:0] arbTag;
  logic [5:0] arbBeats;
  logic [3:0] waitCount;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clk = ~clk;

  bus_arb_waitq #(.DEPTH(DEPTH), .BUS_BYTES(8), .LINE_BYTES(64)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqSize(reqSize), .reqTag(reqTag), .reqReady(reqReady),
    .arbValid(arbValid), .arbKind(arbKind), .arbTag(arbTag),
    .arbBeats(arbBeats), .arbGrant(arbGrant), .waitCount(waitCount),
    .errDupResp(errDupResp)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle from a negedge; outputs are sampled at the next negedge
  task automatic cyc(input logic v, input int k, input int sz, input int tg, input logic g);
    reqValid = v; reqKind = 3'(k); reqSize = 8'(sz); reqTag = 8'(tg); arbGrant = g;
    @(negedge clk);
    reqValid = 1'b0; arbGrant = 1'b0;
  endtask

  task automatic expectPres(input string req, input int tg, input int cnt);
    chk({req, " valid"}, int'(arbValid), 1);
    chk({req, " tag"}, int'(arbTag), tg);
    chk({req, " count"}, int'(waitCount), cnt);
  endtask

  task automatic t_reset();
    chk("R1 valid", int'(arbValid), 0);
    chk("R1 count", int'(waitCount), 0);
    chk("R1 ready", int'(reqReady), 1);
    chk("R1 err", int'(errDupResp), 0);
  endtask

  task automatic t_fifo_order();
    cyc(1, 0, 0, 1, 0);
    expectPres("R2 idle", 1, 1);
    chk("R9 coh beats", int'(arbBeats), 1);
    cyc(1, 2, 20, 2, 0);
    cyc(1, 3, 8, 3, 0);
    expectPres("R3 tail", 1, 3);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    expectPres("R7 hold", 1, 3);
    cyc(0, 0, 0, 0, 1);
    expectPres("R4 next", 2, 2);
    chk("R9 write beats", int'(arbBeats), 4);
    cyc(0, 0, 0, 0, 1);
    expectPres("R4 next2", 3, 1);
    chk("R9 swap beats", int'(arbBeats), 2);
    cyc(0, 0, 0, 0, 1);
    chk("R4 empty valid", int'(arbValid), 0);
    chk("R4 empty count", int'(waitCount), 0);
  endtask

  task automatic t_preempt();
    cyc(1, 0, 0, 10, 0);
    cyc(1, 1, 4, 11, 0);
    cyc(1, 4, 64, 12, 0);
    expectPres("R5 resp", 12, 3);
    chk("R9 resp beats", int'(arbBeats), 8);
    cyc(0, 0, 0, 0, 1);
    expectPres("R5 displaced head", 10, 2);
    cyc(0, 0, 0, 0, 1);
    expectPres("R5 then tail", 11, 1);
    chk("R9 read beats", int'(arbBeats), 1);
    cyc(0, 0, 0, 0, 1);
    chk("R5 drained", int'(waitCount), 0);
  endtask

  task automatic t_dup();
    cyc(1, 0, 0, 20, 0);
    cyc(1, 4, 64, 21, 0);
    cyc(1, 4, 64, 22, 0);
    chk("R8 err pulse", int'(errDupResp), 1);
    expectPres("R8 unchanged", 21, 2);
    cyc(0, 0, 0, 0, 0);
    chk("R8 err single", int'(errDupResp), 0);
    cyc(0, 0, 0, 0, 1);
    expectPres("R8 after", 20, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R8 drained", int'(waitCount), 0);
  endtask

  task automatic t_same_cycle();
    cyc(1, 0, 0, 30, 0);
    cyc(1, 0, 0, 31, 0);
    cyc(1, 0, 0, 32, 1);
    expectPres("R11 grant+req", 31, 2);
    cyc(0, 0, 0, 0, 1);
    expectPres("R11 tail", 32, 1);
    cyc(1, 4, 64, 41, 1);
    expectPres("R6 grant+resp", 41, 1);
    chk("R6 err", int'(errDupResp), 0);
    cyc(0, 0, 0, 0, 1);
    chk("R6 drained", int'(arbValid), 0);
  endtask

  task automatic t_full();
    for (int i = 0; i <= DEPTH; i++) cyc(1, 0, 0, 50 + i, 0);
    chk("R10 count", int'(waitCount), DEPTH + 1);
    chk("R10 ready low", int'(reqReady), 0);
    cyc(1, 0, 0, 99, 0);
    chk("R10 ignored", int'(waitCount), DEPTH + 1);
    cyc(1, 4, 64, 98, 0);
    expectPres("R10 resp ignored", 50, DEPTH + 1);
    for (int i = 1; i <= DEPTH; i++) begin
      cyc(0, 0, 0, 0, 1);
      expectPres("R10 drain", 50 + i, DEPTH + 1 - i);
    end
    cyc(0, 0, 0, 0, 1);
    chk("R10 empty", int'(arbValid), 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_fifo_order();
    t_preempt();
    t_dup();
    t_same_cycle();
    t_full();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule